// File: doc/BRIEF.md
# Per-Core Private Interrupt Bank

This block keeps the state of the 32 interrupts that belong to a single processor core. IDs 0 to 15 are software-generated and IDs 16 to 31 come from private peripherals. For every ID it holds a pending bit, an active bit, an enable bit and a group bit. It also holds a trigger-configuration word for the peripheral IDs, eight stored priority words and a sleep flag.

Sources mark an ID pending through a raise strobe. The raise strobe returns a flag saying whether the bit was clear before, and the caller uses that flag to wake the core. The core takes interrupts through an acknowledge port. On each acknowledge the highest-numbered bit that is pending and not active moves to active. The core retires an interrupt through an end-of-interrupt port. A single `irqPending` line tells the core that a deliverable interrupt exists.

Software reaches the state through a register port. That port has two frames, and address bit 16 selects between them. Reads are combinational and have no side effects. Writes take effect at the next clock edge.

Top module: `core_irq_bank`

## Requirements
- R1: A raise of ID n sets pending bit n at the next edge. In the cycle of the raise, `raiseWasClear` is 1 exactly when bit n was clear before.
- R2: `irqPending` is 1 exactly when at least one ID is pending, not active, enabled and has its group bit set.
- R3: While `ackReq` is high, `ackValid` reports whether any ID is pending and not active, and `ackId` gives the highest such ID. At the edge that ID is cleared from pending and set in active. With no candidate, `ackValid` is 0 and nothing changes.
- R4: An end-of-interrupt with `eoiId` below 32 clears that active bit. An `eoiId` of 32 or more (bit 5 set) has no effect.
- R5: Address bit 16 selects the frame: 0 for the control frame and 1 for the interrupt frame. In the control frame the interrupt-frame offsets (for example offset 0x080) read 0, and writes to them have no effect.
- R6: The configuration word for IDs 0 to 15 (interrupt frame, offset 0xC00) always reads 0xAAAAAAAA, and writes to it are ignored. The configuration word for IDs 16 to 31 (offset 0xC04) is fully read/write.
- R7: The sleep register (control frame, offset 0x014) stores write bit 1. A read returns the stored flag in both bit 1 and bit 2.
- R8: The identity registers in the control frame read `{27'b0, isLast, 4'b0}` at offset 0x008 and `coreAffinity` (four bytes) at offset 0x00C.
- R9: Enable set (0x100) and active set (0x300) OR the written word into the state. Enable clear (0x180) and active clear (0x380) AND the state with the inverse of the word. Both offsets of a pair read the current word. The group word at 0x080 is read/write.
- R10: The pending word reads back at both 0x200 and 0x280.
- R11: The priority words at 0x400 to 0x41C, indexed by address bits [4:2], are read/write. They have no effect on which ID is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreAffinity | input | 32 | The core's four affinity bytes |
| isLast | input | 1 | Marks the final core of the array |
| raiseValid | input | 1 | Raise strobe |
| raiseId | input | 5 | ID to make pending |
| raiseWasClear | output | 1 | Raised bit was clear before (wake indication) |
| ackReq | input | 1 | Acknowledge request |
| ackValid | output | 1 | An ID is available to acknowledge |
| ackId | output | 5 | ID taken by the acknowledge |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiId | input | 6 | ID to retire; bit 5 set means out of range |
| irqPending | output | 1 | Deliverable interrupt exists |
| regAddr | input | 17 | Register byte address; bit 16 selects the frame |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data |

## Verification
The hardest case to reach is an acknowledge that has to skip over pending IDs because they are already active. Reaching it needs a pending bit that sits below an active bit which is still pending too. The bench gets there by raising several IDs and acknowledging the top one. It then raises that same ID again, so the ID is both pending and active, and checks that the next acknowledge picks the lower ID.

The out-of-range end-of-interrupt case is driven with bit 5 of `eoiId` set. Using the low five bits of an ID that is really active shows that the range check is done in full.

// File: rtl/core_irq_pkg.sv
`timescale 1ns/1ps
package core_irq_pkg;
  localparam int NumIrq   = 32;
  localparam int IdW      = $clog2(NumIrq);
  localparam int DataW    = 32;
  localparam int AddrW    = 17;
  localparam int FrameBit = 16;
  localparam int OffW     = FrameBit;
  localparam int NumPrio  = 8;
  localparam int PrioIdxW = $clog2(NumPrio);

  // control frame offsets
  localparam logic [OffW-1:0] OffIdent0 = 16'h0008;
  localparam logic [OffW-1:0] OffIdent1 = 16'h000C;
  localparam logic [OffW-1:0] OffSleep  = 16'h0014;
  // interrupt frame offsets
  localparam logic [OffW-1:0] OffGroup  = 16'h0080;
  localparam logic [OffW-1:0] OffEnSet  = 16'h0100;
  localparam logic [OffW-1:0] OffEnClr  = 16'h0180;
  localparam logic [OffW-1:0] OffPdSet  = 16'h0200;
  localparam logic [OffW-1:0] OffPdClr  = 16'h0280;
  localparam logic [OffW-1:0] OffActSet = 16'h0300;
  localparam logic [OffW-1:0] OffActClr = 16'h0380;
  localparam logic [OffW-1:0] OffPrio   = 16'h0400;
  localparam logic [OffW-1:0] OffCfgSw  = 16'h0C00;
  localparam logic [OffW-1:0] OffCfgPriv= 16'h0C04;

  localparam logic [DataW-1:0] CfgSwValue = 32'hAAAA_AAAA;
  localparam int SleepBit    = 1;
  localparam int ChildBit    = 2;
  localparam int LastBit     = 4;

  typedef enum logic [3:0] {
    RdZero, RdIdent0, RdIdent1, RdSleep, RdGroup, RdEnable,
    RdPending, RdActive, RdPrio, RdCfgSw, RdCfgPriv
  } rdSelT;

  typedef struct packed {
    logic                grpWr;
    logic                enSet;
    logic                enClr;
    logic                actSet;
    logic                actClr;
    logic                cfgWr;
    logic                prioWr;
    logic [PrioIdxW-1:0] prioIdx;
    logic                sleepWr;
    logic                ackTake;
    logic                eoiTake;
    logic [IdW-1:0]      eoiIdx;
    rdSelT               rdSel;
  } ctrlStrobeT;
endpackage

// File: rtl/core_irq_ctrl.sv
`timescale 1ns/1ps
module core_irq_ctrl
  import core_irq_pkg::*;
(
  input  logic [AddrW-1:0] regAddr,
  input  logic             regWrEn,
  input  logic             ackReq,
  input  logic             ackValid,
  input  logic             eoiValid,
  input  logic [IdW:0]     eoiId,
  output ctrlStrobeT       strobe
);
  localparam int PrioLoBit = PrioIdxW + 2;

  logic            irqFrame;
  logic [OffW-1:0] offset;

  assign irqFrame = regAddr[FrameBit];
  assign offset   = regAddr[OffW-1:0];

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = RdZero;
    strobe.prioIdx = offset[PrioLoBit-1:2];
    strobe.ackTake = ackReq & ackValid;
    strobe.eoiTake = eoiValid & ~eoiId[IdW];
    strobe.eoiIdx  = eoiId[IdW-1:0];
    if (!irqFrame) begin
      unique case (offset)
        OffIdent0: strobe.rdSel = RdIdent0;
        OffIdent1: strobe.rdSel = RdIdent1;
        OffSleep: begin
          strobe.rdSel   = RdSleep;
          strobe.sleepWr = regWrEn;
        end
        default: ;
      endcase
    end else begin
      unique case (offset)
        OffGroup: begin
          strobe.rdSel = RdGroup;
          strobe.grpWr = regWrEn;
        end
        OffEnSet: begin
          strobe.rdSel = RdEnable;
          strobe.enSet = regWrEn;
        end
        OffEnClr: begin
          strobe.rdSel = RdEnable;
          strobe.enClr = regWrEn;
        end
        OffPdSet, OffPdClr: strobe.rdSel = RdPending;
        OffActSet: begin
          strobe.rdSel  = RdActive;
          strobe.actSet = regWrEn;
        end
        OffActClr: begin
          strobe.rdSel  = RdActive;
          strobe.actClr = regWrEn;
        end
        OffCfgSw: strobe.rdSel = RdCfgSw;
        OffCfgPriv: begin
          strobe.rdSel = RdCfgPriv;
          strobe.cfgWr = regWrEn;
        end
        default: begin
          if ((offset[OffW-1:PrioLoBit] == OffPrio[OffW-1:PrioLoBit]) &&
              (offset[1:0] == 2'b00)) begin
            strobe.rdSel  = RdPrio;
            strobe.prioWr = regWrEn;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/core_irq_data.sv
`timescale 1ns/1ps
module core_irq_data
  import core_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [DataW-1:0] regWrData,
  input  logic [DataW-1:0] coreAffinity,
  input  logic             isLast,
  input  logic             raiseValid,
  input  logic [IdW-1:0]   raiseId,
  output logic             raiseWasClear,
  output logic             ackValid,
  output logic [IdW-1:0]   ackId,
  output logic             irqPending,
  output logic [DataW-1:0] regRdData,
  output logic [NumIrq-1:0] pendingVec,
  output logic [NumIrq-1:0] activeVec,
  output logic             sleepFlag
);
  logic [NumIrq-1:0] pendingQ, activeQ, enableQ, groupQ;
  logic [DataW-1:0]  cfgPrivQ;
  logic [DataW-1:0]  prioQ [NumPrio];
  logic              sleepQ;

  logic [NumIrq-1:0] candidates, raiseMask, ackMask, eoiMask;
  logic [NumIrq-1:0] wrMask;

  assign candidates = pendingQ & ~activeQ;
  assign wrMask     = regWrData[NumIrq-1:0];

  always_comb begin
    ackId = '0;
    for (int i = 0; i < NumIrq; i++) begin
      if (candidates[i]) ackId = i[IdW-1:0];
    end
  end

  assign ackValid      = |candidates;
  assign raiseMask     = raiseValid ? (NumIrq'(1) << raiseId) : '0;
  assign ackMask       = strobe.ackTake ? (NumIrq'(1) << ackId) : '0;
  assign eoiMask       = strobe.eoiTake ? (NumIrq'(1) << strobe.eoiIdx) : '0;
  assign raiseWasClear = raiseValid & ~pendingQ[raiseId];
  assign irqPending    = |(candidates & enableQ & groupQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= '0;
      activeQ  <= '0;
      enableQ  <= '0;
      groupQ   <= '0;
      cfgPrivQ <= '0;
      sleepQ   <= 1'b0;
    end else begin
      pendingQ <= (pendingQ & ~ackMask) | raiseMask;
      activeQ  <= (((activeQ | (strobe.actSet ? wrMask : '0))
                   & ~(strobe.actClr ? wrMask : '0)) & ~eoiMask) | ackMask;
      if (strobe.enSet) enableQ <= enableQ | wrMask;
      else if (strobe.enClr) enableQ <= enableQ & ~wrMask;
      if (strobe.grpWr)   groupQ   <= wrMask;
      if (strobe.cfgWr)   cfgPrivQ <= regWrData;
      if (strobe.sleepWr) sleepQ   <= regWrData[SleepBit];
    end
  end

  for (genvar g = 0; g < NumPrio; g++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioQ[g] <= '0;
      else if (strobe.prioWr && (strobe.prioIdx == PrioIdxW'(g))) prioQ[g] <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      RdIdent0:  regRdData[LastBit] = isLast;
      RdIdent1:  regRdData = coreAffinity;
      RdSleep: begin
        regRdData[SleepBit] = sleepQ;
        regRdData[ChildBit] = sleepQ;
      end
      RdGroup:   regRdData = DataW'(groupQ);
      RdEnable:  regRdData = DataW'(enableQ);
      RdPending: regRdData = DataW'(pendingQ);
      RdActive:  regRdData = DataW'(activeQ);
      RdPrio:    regRdData = prioQ[strobe.prioIdx];
      RdCfgSw:   regRdData = CfgSwValue;
      RdCfgPriv: regRdData = cfgPrivQ;
      default:   regRdData = '0;
    endcase
  end

  assign pendingVec = pendingQ;
  assign activeVec  = activeQ;
  assign sleepFlag  = sleepQ;
endmodule

// File: rtl/core_irq_bank.sv
`timescale 1ns/1ps
module core_irq_bank
  import core_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      coreAffinity,
  input  logic             isLast,
  input  logic             raiseValid,
  input  logic [4:0]       raiseId,
  output logic             raiseWasClear,
  input  logic             ackReq,
  output logic             ackValid,
  output logic [4:0]       ackId,
  input  logic             eoiValid,
  input  logic [5:0]       eoiId,
  output logic             irqPending,
  input  logic [16:0]      regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData
);
  ctrlStrobeT        strobe;
  logic [NumIrq-1:0] pendingVec, activeVec;
  logic              sleepFlag;

  core_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .ackReq  (ackReq),
    .ackValid(ackValid),
    .eoiValid(eoiValid),
    .eoiId   (eoiId),
    .strobe  (strobe)
  );

  core_irq_data u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .regWrData    (regWrData),
    .coreAffinity (coreAffinity),
    .isLast       (isLast),
    .raiseValid   (raiseValid),
    .raiseId      (raiseId),
    .raiseWasClear(raiseWasClear),
    .ackValid     (ackValid),
    .ackId        (ackId),
    .irqPending   (irqPending),
    .regRdData    (regRdData),
    .pendingVec   (pendingVec),
    .activeVec    (activeVec),
    .sleepFlag    (sleepFlag)
  );
endmodule

// File: rtl/core_irq_bank_chk.sv
`timescale 1ns/1ps
module core_irq_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        raiseValid,
  input logic [4:0]  raiseId,
  input logic        ackReq,
  input logic        ackValid,
  input logic [4:0]  ackId,
  input logic        eoiValid,
  input logic [5:0]  eoiId,
  input logic        irqPending,
  input logic        regWrEn,
  input logic [31:0] pendingQ,
  input logic [31:0] activeQ,
  input logic        sleepQ
);
  p_raise_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    raiseValid |=> pendingQ[$past(raiseId)]);

  p_irq_needs_candidate_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> ackValid);

  p_ack_choice_r3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (pendingQ[ackId] && !activeQ[ackId]));

  p_ack_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && ackValid && !(raiseValid && raiseId == ackId))
    |=> (activeQ[$past(ackId)] && !pendingQ[$past(ackId)]));

  p_eoi_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && !eoiId[5] && !regWrEn && !(ackReq && ackValid && ackId == eoiId[4:0]))
    |=> !activeQ[$past(eoiId[4:0])]);

  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(sleepQ));
endmodule

bind core_irq_bank core_irq_bank_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .raiseValid(raiseValid),
  .raiseId   (raiseId),
  .ackReq    (ackReq),
  .ackValid  (ackValid),
  .ackId     (ackId),
  .eoiValid  (eoiValid),
  .eoiId     (eoiId),
  .irqPending(irqPending),
  .regWrEn   (regWrEn),
  .pendingQ  (pendingVec),
  .activeQ   (activeVec),
  .sleepQ    (sleepFlag)
);

// File: tb/core_irq_bank_bench.sv
`timescale 1ns/1ps
module core_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] coreAffinity = 32'h0A0B_0C0D;
  logic        isLast = 1'b1;
  logic        raiseValid = 1'b0;
  logic [4:0]  raiseId = '0;
  logic        raiseWasClear;
  logic        ackReq = 1'b0;
  logic        ackValid;
  logic [4:0]  ackId;
  logic        eoiValid = 1'b0;
  logic [5:0]  eoiId = '0;
  logic        irqPending;
  logic [16:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  core_irq_bank u_core_irq_bank (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [16:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [16:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic raise(input logic [4:0] id, output logic wasClear);
    raiseValid = 1'b1; raiseId = id; #1;
    wasClear = raiseWasClear;
    @(posedge clk); #1;
    raiseValid = 1'b0;
  endtask

  task automatic ack(output logic v, output logic [4:0] id);
    ackReq = 1'b1; #1;
    v = ackValid; id = ackId;
    @(posedge clk); #1;
    ackReq = 1'b0;
  endtask

  task automatic eoi(input logic [5:0] id);
    eoiValid = 1'b1; eoiId = id;
    @(posedge clk); #1;
    eoiValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R2 reset irq", 32'(irqPending), 0);
    check("R3 reset ackValid", 32'(ackValid), 0);
    regRd(17'h10200, d); check("R10 reset pending", d, 0);
  endtask

  task automatic t_raise();
    logic w; logic [31:0] d;
    raise(5'd5, w); check("R1 first raise wake", 32'(w), 1);
    raise(5'd5, w); check("R1 repeat raise no wake", 32'(w), 0);
    regRd(17'h10200, d); check("R1 pending word", d, 32'h20);
  endtask

  task automatic t_irq();
    check("R2 disabled no irq", 32'(irqPending), 0);
    regWr(17'h10100, 32'h20);
    check("R2 group clear no irq", 32'(irqPending), 0);
    regWr(17'h10080, 32'h20);
    check("R2 deliverable irq", 32'(irqPending), 1);
    regWr(17'h10300, 32'h20);
    check("R2 active blocks irq", 32'(irqPending), 0);
    regWr(17'h10380, 32'h20);
    check("R2 irq back after active clear", 32'(irqPending), 1);
  endtask

  task automatic t_ack_eoi();
    logic w, v; logic [4:0] id; logic [31:0] d;
    raise(5'd3, w);
    ack(v, id);
    check("R3 ack valid", 32'(v), 1);
    check("R3 ack highest", 32'(id), 5);
    raise(5'd5, w);   // 5 now pending and active, 3 pending
    ack(v, id);
    check("R3 ack skips active", 32'(id), 3);
    regRd(17'h10300, d); check("R3 active word", d, 32'h28);
    regRd(17'h10280, d); check("R10 pending via clear offset", d, 32'h20);
    ack(v, id);
    check("R3 nothing left", 32'(v), 0);
    eoi(6'd37);
    regRd(17'h10300, d); check("R4 eoi out of range ignored", d, 32'h28);
    eoi(6'd5);
    regRd(17'h10300, d); check("R4 eoi clears 5", d, 32'h08);
    eoi(6'd3);
    regRd(17'h10380, d); check("R4 eoi clears 3", d, 32'h0);
    ack(v, id);
    check("R3 re-ack pending 5", 32'(id), 5);
    eoi(6'd5);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    regWr(17'h10180, 32'h20);
    regRd(17'h10100, d); check("R9 enable clear", d, 0);
    regWr(17'h10100, 32'h3);
    regWr(17'h10100, 32'h4);
    regRd(17'h10180, d); check("R9 enable OR", d, 32'h7);
    regWr(17'h10300, 32'h100);
    regWr(17'h10300, 32'h001);
    regWr(17'h10380, 32'h100);
    regRd(17'h10300, d); check("R9 active set/clear", d, 32'h1);
    regWr(17'h10380, 32'h1);
  endtask

  task automatic t_frames();
    logic [31:0] d;
    regWr(17'h00080, 32'hFFFF_FFFF);
    regRd(17'h10080, d); check("R5 control frame write no effect", d, 32'h20);
    regRd(17'h00080, d); check("R5 control frame reads zero", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    regRd(17'h10C00, d); check("R6 sw cfg constant", d, 32'hAAAA_AAAA);
    regWr(17'h10C00, 32'h0);
    regRd(17'h10C00, d); check("R6 sw cfg write ignored", d, 32'hAAAA_AAAA);
    regWr(17'h10C04, 32'h1234_5678);
    regRd(17'h10C04, d); check("R6 priv cfg rw", d, 32'h1234_5678);
  endtask

  task automatic t_sleep_ident();
    logic [31:0] d;
    regWr(17'h00014, 32'h2);
    regRd(17'h00014, d); check("R7 sleep both bits", d, 32'h6);
    regWr(17'h00014, 32'h0);
    regRd(17'h00014, d); check("R7 sleep cleared", d, 32'h0);
    regRd(17'h00008, d); check("R8 last flag", d, 32'h10);
    regRd(17'h0000C, d); check("R8 affinity", d, 32'h0A0B_0C0D);
  endtask

  task automatic t_prio();
    logic w, v; logic [4:0] id; logic [31:0] d;
    regWr(17'h10404, 32'h11);
    regWr(17'h1041C, 32'h77);
    regWr(17'h10400, 32'hFF);
    regRd(17'h10404, d); check("R11 prio word 1", d, 32'h11);
    regRd(17'h1041C, d); check("R11 prio word 7", d, 32'h77);
    regRd(17'h10408, d); check("R11 prio word 2 untouched", d, 32'h0);
    raise(5'd31, w);
    raise(5'd0, w);
    regRd(17'h10200, d); check("R10 pending edges", d, 32'h8000_0001);
    ack(v, id);
    check("R11 prio ignored, R3 top id", 32'(id), 31);
    ack(v, id);
    check("R3 lowest id", 32'(id), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_raise();
    t_irq();
    t_ack_eoi();
    t_set_clear();
    t_frames();
    t_cfg();
    t_sleep_ident();
    t_prio();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule